// File: doc/BRIEF.md
# Transmit Radio State Controller

This block sequences a transmit-only radio through its operating states. Four command strobes (transmit, idle, calibrate, synthesizer-on) drive it out of idle. It spends a fixed number of crystal-clock cycles in each calibration and settling interval, and it holds transmission until the packet engine reports that the packet is done. After each packet a two-bit setting picks where the controller goes next. A separate two-bit policy input picks when the synthesizer is calibrated automatically.

All intervals are timed by one shared down-counter, which is loaded when a timed state is entered. A two-bit counter records how many times a packet has ended with a return to idle. The every-fourth calibration policy uses this counter, and a manual calibration clears it. The idle strobe overrides everything else and returns the controller to idle on the next clock.

Top module: `rctl_tx_ctrl`

## Requirements
- R1: After reset, `state` reads 0 (idle) and `synth_en`, `cal_busy` and `tx_en` are all low.
- R2: The state codes are: 0 idle, 1 manual calibration, 2 calibration before settling, 3 settling, 4 synthesizer-on, 5 transmit, 6 short exit, 7 calibration on exit. `synth_en` is high in codes 1 to 5 and 7. `cal_busy` is high in codes 1, 2 and 7. `tx_en` is high only in code 5.
- R3: A calibrate strobe in idle enters code 1 for exactly CAL_CYCLES cycles (default 18739), then returns to idle. It also clears the exit counter.
- R4: A transmit strobe or a synthesizer-on strobe in idle starts the settling path. With `cal_policy` = 1 the controller spends CAL_CYCLES cycles in code 2 first. In all cases it then spends SETTLE_CYCLES cycles (default 2298) in code 3, and ends in code 5 for a transmit strobe or code 4 for a synthesizer-on strobe.
- R5: Code 5 is held until `pkt_done` is seen. `pkt_done` in any other state has no effect.
- R6: When `pkt_done` is seen in code 5, `after_pkt` picks the next state. A value of 1 moves to code 4 on the next cycle. A value of 2 stays in code 5. A value of 0 or 3 takes the exit path.
- R7: On the exit path, `cal_policy` = 2 spends CAL_CYCLES cycles in code 7 and then goes to idle. `cal_policy` = 0 or 1 spends EXIT_CYCLES cycles (default 2) in code 6 and then goes to idle.
- R8: Each exit path taken adds one to a 2-bit counter, which is zero after reset. With `cal_policy` = 3, the exit calibrates (code 7) only when that increment wraps the counter to zero, and otherwise uses code 6.
- R9: `stb_idle` moves the controller to code 0 on the next cycle from any state. This aborts any calibration, settling or transmission in progress.
- R10: When several strobes arrive in the same cycle, only the highest-priority one is considered: idle, then calibrate, then transmit, then synthesizer-on. If that winner does not apply to the current state, it is dropped and the lower strobes are lost. A strobe that does not apply to the current state does nothing.
- R11: In code 4, a transmit strobe moves to code 5 on the next cycle. The synthesizer-on and calibrate strobes do nothing there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_tx | input | 1 | Transmit strobe |
| stb_idle | input | 1 | Force-idle strobe |
| stb_cal | input | 1 | Manual calibration strobe |
| stb_synon | input | 1 | Synthesizer-on strobe |
| cal_policy | input | 2 | 0 never, 1 before settling, 2 on exit, 3 every fourth exit |
| after_pkt | input | 2 | 0 idle, 1 synthesizer-on, 2 transmit again, 3 idle |
| pkt_done | input | 1 | Packet engine reports the packet fully sent |
| state | output | 3 | Current state code |
| synth_en | output | 1 | Synthesizer enable |
| cal_busy | output | 1 | Calibration in progress |
| tx_en | output | 1 | Transmit grant to the packet engine |

## Verification
The bench drives the settling path under every calibration policy. Starting it from both the transmit strobe and the synthesizer-on strobe separates the two end states and shows whether the pre-calibration is inserted. Runs of packet endings under the every-fourth policy, some with a manual calibration in between, show whether the exit counter wraps and clears correctly. Coincident strobes, out-of-state strobes and idle aborts in timed states exercise the priority order and the override. A cycle-accurate model is compared against the design on every clock, and separate checks at the interval boundaries pin down the exact latencies.

// File: rtl/rctl_pkg.sv
package rctl_pkg;

  typedef enum logic [2:0] {
    RS_IDLE     = 3'd0,
    RS_CAL_MAN  = 3'd1,
    RS_CAL_PRE  = 3'd2,
    RS_SETTLE   = 3'd3,
    RS_SYN_ON   = 3'd4,
    RS_TX       = 3'd5,
    RS_EXIT     = 3'd6,
    RS_CAL_POST = 3'd7
  } rstate_e;

  typedef enum logic [1:0] {
    CP_NEVER = 2'd0,
    CP_START = 2'd1,
    CP_END   = 2'd2,
    CP_END4  = 2'd3
  } cpol_e;

  typedef enum logic [1:0] {
    AP_IDLE  = 2'd0,
    AP_SYNON = 2'd1,
    AP_TX    = 2'd2,
    AP_RSVD  = 2'd3
  } apkt_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_IDLE = 3'd1,
    CMD_CAL  = 3'd2,
    CMD_TX   = 3'd3,
    CMD_SYN  = 3'd4
  } cmd_e;

  // synthesizer is powered everywhere except idle and the short exit
  function automatic logic synth_active(rstate_e s);
    return !(s == RS_IDLE || s == RS_EXIT);
  endfunction

  function automatic logic cal_active(rstate_e s);
    return (s == RS_CAL_MAN) || (s == RS_CAL_PRE) || (s == RS_CAL_POST);
  endfunction

  // states whose duration is set by the shared down-counter
  function automatic logic timed_state(rstate_e s);
    return (s == RS_CAL_MAN) || (s == RS_CAL_PRE) || (s == RS_SETTLE) ||
           (s == RS_EXIT) || (s == RS_CAL_POST);
  endfunction

endpackage

// File: rtl/rctl_strobe_arb.sv
module rctl_strobe_arb
  import rctl_pkg::*;
(
  input  logic stb_idle,
  input  logic stb_cal,
  input  logic stb_tx,
  input  logic stb_synon,
  output cmd_e cmd
);

  // fixed priority: idle, calibrate, transmit, synthesizer-on
  always_comb begin
    if (stb_idle)       cmd = CMD_IDLE;
    else if (stb_cal)   cmd = CMD_CAL;
    else if (stb_tx)    cmd = CMD_TX;
    else if (stb_synon) cmd = CMD_SYN;
    else                cmd = CMD_NONE;
  end

endmodule

// File: rtl/rctl_timer.sv
module rctl_timer #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/rctl_cal_sched.sv
module rctl_cal_sched
  import rctl_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  cpol_e policy,
  input  logic  exit_evt,
  input  logic  clr,
  output logic  cal_at_start,
  output logic  cal_at_exit
);

  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  // an exit calibrates when the policy says so; the periodic policy
  // only when this exit wraps the counter back to zero
  function automatic logic exit_cal_due(cpol_e p, logic [CNT_W-1:0] c);
    return (p == CP_END) || ((p == CP_END4) && (c == LAST));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (exit_evt) cnt_q <= cnt_q + 1'b1;
  end

  assign cal_at_start = (policy == CP_START);
  assign cal_at_exit  = exit_cal_due(policy, cnt_q);

  // periodic calibration must leave the counter at zero
  p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_evt && !clr && policy == CP_END4 && cal_at_exit) |=> (cnt_q == '0));

  // a manual calibration restarts the count
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/rctl_tx_ctrl.sv
module rctl_tx_ctrl
  import rctl_pkg::*;
#(
  parameter int CAL_CYCLES    = 18739,
  parameter int SETTLE_CYCLES = 2298,
  parameter int EXIT_CYCLES   = 2,
  parameter int TMR_W         = 15,
  parameter int EXIT_CNT_W    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb_tx,
  input  logic       stb_idle,
  input  logic       stb_cal,
  input  logic       stb_synon,
  input  logic [1:0] cal_policy,
  input  logic [1:0] after_pkt,
  input  logic       pkt_done,
  output logic [2:0] state,
  output logic       synth_en,
  output logic       cal_busy,
  output logic       tx_en
);

  // a state of N cycles loads N-1 and leaves when the counter shows zero
  localparam logic [TMR_W-1:0] LD_CAL    = TMR_W'(CAL_CYCLES - 1);
  localparam logic [TMR_W-1:0] LD_SETTLE = TMR_W'(SETTLE_CYCLES - 1);
  localparam logic [TMR_W-1:0] LD_EXIT   = TMR_W'(EXIT_CYCLES - 1);

  rstate_e          st_q, st_d;
  rstate_e          tgt_q, tgt_d;
  cmd_e             cmd;
  logic             expire;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             exit_evt;
  logic             man_cal;
  logic             cal_at_start;
  logic             cal_at_exit;
  cpol_e            policy;
  apkt_e            dest;

  assign policy = cpol_e'(cal_policy);
  assign dest   = apkt_e'(after_pkt);

  rctl_strobe_arb u_arb (
    .stb_idle  (stb_idle),
    .stb_cal   (stb_cal),
    .stb_tx    (stb_tx),
    .stb_synon (stb_synon),
    .cmd       (cmd)
  );

  rctl_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (expire)
  );

  rctl_cal_sched #(.CNT_W(EXIT_CNT_W)) u_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .policy       (policy),
    .exit_evt     (exit_evt),
    .clr          (man_cal),
    .cal_at_start (cal_at_start),
    .cal_at_exit  (cal_at_exit)
  );

  always_comb begin
    st_d     = st_q;
    tgt_d    = tgt_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    exit_evt = 1'b0;
    man_cal  = 1'b0;
    if (cmd == CMD_IDLE) begin
      st_d     = RS_IDLE;
      tmr_load = 1'b1;
    end else begin
      unique case (st_q)
        RS_IDLE: begin
          if (cmd == CMD_CAL) begin
            st_d     = RS_CAL_MAN;
            tmr_load = 1'b1;
            tmr_val  = LD_CAL;
            man_cal  = 1'b1;
          end else if (cmd == CMD_TX || cmd == CMD_SYN) begin
            tgt_d    = (cmd == CMD_TX) ? RS_TX : RS_SYN_ON;
            tmr_load = 1'b1;
            if (cal_at_start) begin
              st_d    = RS_CAL_PRE;
              tmr_val = LD_CAL;
            end else begin
              st_d    = RS_SETTLE;
              tmr_val = LD_SETTLE;
            end
          end
        end
        RS_CAL_PRE: begin
          if (expire) begin
            st_d     = RS_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = LD_SETTLE;
          end
        end
        RS_SETTLE: begin
          if (expire) st_d = tgt_q;
        end
        RS_SYN_ON: begin
          if (cmd == CMD_TX) st_d = RS_TX;
        end
        RS_TX: begin
          if (pkt_done) begin
            unique case (dest)
              AP_SYNON: st_d = RS_SYN_ON;
              AP_TX:    st_d = RS_TX;
              default: begin
                exit_evt = 1'b1;
                tmr_load = 1'b1;
                if (cal_at_exit) begin
                  st_d    = RS_CAL_POST;
                  tmr_val = LD_CAL;
                end else begin
                  st_d    = RS_EXIT;
                  tmr_val = LD_EXIT;
                end
              end
            endcase
          end
        end
        RS_CAL_MAN, RS_EXIT, RS_CAL_POST: begin
          if (expire) st_d = RS_IDLE;
        end
        default: st_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RS_IDLE;
      tgt_q <= RS_TX;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
    end
  end

  assign state    = st_q;
  assign synth_en = synth_active(st_q);
  assign cal_busy = cal_active(st_q);
  assign tx_en    = (st_q == RS_TX);

  // idle strobe overrides every state
  p_idle_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stb_idle |=> (st_q == RS_IDLE));

  // transmission is held until the packet engine finishes
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_TX && !pkt_done && !stb_idle) |=> (st_q == RS_TX));

  // a timed state is not left before its counter runs out
  p_timed_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_state(st_q) && !expire && !stb_idle) |=> $stable(st_q));

  // packet-done outside transmission does not disturb idle
  p_done_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_IDLE && pkt_done && !stb_cal && !stb_tx && !stb_synon)
      |=> (st_q == RS_IDLE));

  // an exit event always leaves transmission for an exit state
  p_exit_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> (st_q == RS_EXIT || st_q == RS_CAL_POST));

  // calibration only ever runs with the synthesizer enabled
  p_cal_synth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> synth_en);

endmodule

// File: tb/sim_rctl_tx_ctrl.sv
`timescale 1ns/1ps
module sim_rctl_tx_ctrl;

  localparam int CAL = 40;
  localparam int SET = 12;
  localparam int EXT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb_tx = 1'b0, stb_idle = 1'b0, stb_cal = 1'b0, stb_synon = 1'b0;
  logic [1:0] cal_policy = 2'd0;
  logic [1:0] after_pkt = 2'd0;
  logic       pkt_done = 1'b0;
  logic [2:0] state;
  logic       synth_en, cal_busy, tx_en;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  rctl_tx_ctrl #(
    .CAL_CYCLES(CAL), .SETTLE_CYCLES(SET), .EXIT_CYCLES(EXT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .stb_tx(stb_tx), .stb_idle(stb_idle),
    .stb_cal(stb_cal), .stb_synon(stb_synon), .cal_policy(cal_policy),
    .after_pkt(after_pkt), .pkt_done(pkt_done), .state(state),
    .synth_en(synth_en), .cal_busy(cal_busy), .tx_en(tx_en)
  );

  // behavioural reference: remaining cycles counted including the current one
  int m_st = 0, m_left = 0, m_exits = 0, m_tgt = 5;

  always @(posedge clk) begin
    int c;
    if (!rst_n) begin
      m_st = 0; m_left = 0; m_exits = 0;
    end else begin
      c = stb_idle ? 1 : stb_cal ? 2 : stb_tx ? 3 : stb_synon ? 4 : 0;
      if (c == 1) m_st = 0;
      else case (m_st)
        0: if (c == 2) begin
             m_st = 1; m_left = CAL; m_exits = 0;
           end else if (c == 3 || c == 4) begin
             m_tgt = (c == 3) ? 5 : 4;
             if (cal_policy == 2'd1) begin m_st = 2; m_left = CAL; end
             else begin m_st = 3; m_left = SET; end
           end
        1, 6, 7: if (m_left <= 1) m_st = 0; else m_left--;
        2: if (m_left <= 1) begin m_st = 3; m_left = SET; end else m_left--;
        3: if (m_left <= 1) m_st = m_tgt; else m_left--;
        4: if (c == 3) m_st = 5;
        5: if (pkt_done) begin
             if (after_pkt == 2'd1) m_st = 4;
             else if (after_pkt != 2'd2) begin
               m_exits = (m_exits + 1) % 4;
               if (cal_policy == 2'd2 || (cal_policy == 2'd3 && m_exits == 0)) begin
                 m_st = 7; m_left = CAL;
               end else begin
                 m_st = 6; m_left = EXT;
               end
             end
           end
        default: m_st = 0;
      endcase
    end
  end

  // per-cycle comparison, R2 output decode included
  always @(negedge clk) begin
    int exp_w;
    int act_w;
    if (rst_n && !ended) begin
      exp_w = m_st * 8 + ((m_st != 0 && m_st != 6) ? 4 : 0)
            + ((m_st == 1 || m_st == 2 || m_st == 7) ? 2 : 0) + ((m_st == 5) ? 1 : 0);
      act_w = int'(state) * 8 + int'(synth_en) * 4 + int'(cal_busy) * 2 + int'(tx_en);
      checks++;
      if (act_w != exp_w) begin
        errors++;
        $display("FAIL %s model compare: state/synth/cal/tx actual=%0h expected=%0h",
                 cur_req, act_w, exp_w);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic i, input logic c, input logic t, input logic s);
    @(negedge clk);
    stb_idle = i; stb_cal = c; stb_tx = t; stb_synon = s;
    @(negedge clk);
    stb_idle = 0; stb_cal = 0; stb_tx = 0; stb_synon = 0;
  endtask

  task automatic done(input logic [1:0] a);
    @(negedge clk);
    after_pkt = a; pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
  endtask

  // one transmit cycle ending on the exit path; returns the first exit state
  task automatic tx_round(output int first_exit);
    strobe(0, 0, 1, 0);
    run(SET);
    done(2'd0);
    first_exit = int'(state);
    run(CAL + 2);
  endtask

  task automatic finish_run();
    ended = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    run(3);
    cur_req = "R1";
    chk("R1 state", int'(state), 0);
    chk("R1 outputs", int'({synth_en, cal_busy, tx_en}), 0);
    rst_n = 1'b1;
    run(2);

    // R3 manual calibration duration
    cur_req = "R3";
    strobe(0, 1, 0, 0);
    chk("R3 entered", int'(state), 1);
    chk("R2 cal_busy", int'(cal_busy), 1);
    run(CAL - 1);
    chk("R3 still calibrating", int'(state), 1);
    run(1);
    chk("R3 back to idle", int'(state), 0);

    // R4 settling without calibration
    cur_req = "R4";
    cal_policy = 2'd0;
    strobe(0, 0, 1, 0);
    chk("R4 settling", int'(state), 3);
    run(SET - 1);
    chk("R4 settle held", int'(state), 3);
    run(1);
    chk("R4 in transmit", int'(state), 5);
    chk("R2 tx_en", int'(tx_en), 1);

    // R5 held while packet runs; R7 short exit
    cur_req = "R5";
    run(20);
    chk("R5 holds transmit", int'(state), 5);
    cur_req = "R7";
    done(2'd0);
    chk("R7 short exit", int'(state), 6);
    chk("R2 synth off in exit", int'(synth_en), 0);
    run(EXT - 1);
    chk("R7 exit held", int'(state), 6);
    run(1);
    chk("R7 idle after exit", int'(state), 0);

    // R4 with calibration first, ending in synthesizer-on
    cur_req = "R4";
    cal_policy = 2'd1;
    strobe(0, 0, 0, 1);
    chk("R4 pre-cal", int'(state), 2);
    run(CAL - 1);
    chk("R4 pre-cal held", int'(state), 2);
    run(1);
    chk("R4 settle after cal", int'(state), 3);
    run(SET);
    chk("R4 synth-on reached", int'(state), 4);

    // R11 / R10 in synthesizer-on
    cur_req = "R11";
    strobe(0, 0, 0, 1);
    chk("R11 synon ignored", int'(state), 4);
    strobe(0, 1, 1, 0);
    chk("R10 cal beats tx in synon", int'(state), 4);
    strobe(0, 0, 1, 0);
    chk("R11 tx from synon", int'(state), 5);

    // R6 destinations
    cur_req = "R6";
    done(2'd2);
    chk("R6 transmit again", int'(state), 5);
    cur_req = "R10";
    strobe(0, 1, 0, 1);
    chk("R10 cal in transmit ignored", int'(state), 5);
    cur_req = "R6";
    done(2'd1);
    chk("R6 to synth-on", int'(state), 4);
    cur_req = "R9";
    strobe(1, 0, 0, 0);
    chk("R9 idle from synth-on", int'(state), 0);

    // R7 calibration on exit
    cur_req = "R7";
    cal_policy = 2'd2;
    strobe(0, 0, 1, 0);
    run(SET);
    done(2'd3);
    chk("R7 post-cal", int'(state), 7);
    run(CAL - 1);
    chk("R7 post-cal held", int'(state), 7);
    run(1);
    chk("R7 idle after post-cal", int'(state), 0);

    // R8 every fourth exit; clear with manual calibration first
    cur_req = "R8";
    cal_policy = 2'd3;
    strobe(0, 1, 0, 0);
    run(CAL + 1);
    for (int i = 1; i <= 4; i++) begin
      int fx;
      tx_round(fx);
      chk("R8 periodic exit", fx, (i == 4) ? 7 : 6);
    end
    begin
      int fx;
      tx_round(fx);
      tx_round(fx);
      cur_req = "R3";
      strobe(0, 1, 0, 0);
      run(CAL + 1);
      cur_req = "R8";
      for (int i = 1; i <= 4; i++) begin
        tx_round(fx);
        chk("R8 count cleared by manual cal", fx, (i == 4) ? 7 : 6);
      end
    end

    // R9 aborts
    cur_req = "R9";
    cal_policy = 2'd1;
    strobe(0, 0, 1, 0);
    run(5);
    strobe(1, 0, 0, 0);
    chk("R9 abort calibration", int'(state), 0);
    chk("R9 synth off", int'(synth_en), 0);
    cal_policy = 2'd0;
    strobe(0, 0, 1, 0);
    run(SET);
    strobe(1, 0, 0, 0);
    chk("R9 abort transmit", int'(state), 0);

    // R10 coincident strobes and R5 stray done
    cur_req = "R10";
    strobe(0, 1, 1, 1);
    chk("R10 cal beats tx", int'(state), 1);
    strobe(1, 1, 1, 0);
    chk("R10 idle beats all", int'(state), 0);
    run(2);
    chk("R10 nothing pending", int'(state), 0);
    cur_req = "R5";
    done(2'd0);
    chk("R5 stray done ignored", int'(state), 0);
    run(3);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL %s watchdog expired actual=20000 expected=<20000 cycles", cur_req);
    finish_run();
  end

endmodule